// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a load/store data cache that sits between a processor pipeline and a word-wide memory port. Each set holds two ways. Every way keeps a valid flag, a dirty flag, a tag and a block of several 32-bit words. The set index is taken from the address, and both tags of that set are compared at the same time. A single recency bit per set picks which way is replaced when a new block has to be brought in.

The processor presents a request with a word address, a write flag, write data and a byte mask. It holds the request until the stall output drops. A hit completes in the cycle it is presented. A miss stalls the processor while the block moves over the memory port as a burst of word beats, each one under a valid/ready handshake. A dirty victim is written out before the new block is fetched. A parameter selects the store policy. The default is write-back with write-allocate. The other setting is write-through with no-write-allocate, where every store makes one masked word write to memory.

With the default geometry there are 64 sets, 2 ways and 4 words per block. The 32-bit byte address therefore splits into a 4-bit byte offset, a 6-bit set index and a 22-bit tag. The processor and memory ports carry the word address, which is byte address bits 31..2.

Top module: `dcache_2way`

## Requirements
- R1: Bits [1:0] of the word address select the word within the block, bits [7:2] select the set and bits [29:8] form the tag.
- R2: A request hits when a valid way of its set holds a matching tag. A hit read returns the addressed word in the same cycle with `cpu_stall` low, and makes no memory traffic.
- R3: On a miss, an invalid way is filled before a valid one, and way 0 is filled before way 1. When both ways are valid, the way not used most recently is replaced. Hits and fills both update the recency.
- R4: A read miss holds `cpu_stall` high and fetches the whole block as 4 read beats at word offsets 0, 1, 2, 3 in that order. After the last beat the request completes with the fetched word.
- R5: A store changes only the bytes whose `cpu_be` bit is set. Mask bit i covers data bits 8i+7..8i.
- R6: In write-back mode a store hit updates only the cached block, marks it dirty and makes no memory traffic.
- R7: In write-back mode, a miss whose victim is dirty first writes the 4 victim words to the victim's own address, then fetches the new block. A clean victim is dropped without a write.
- R8: In write-back mode a store miss fetches the block, then applies the store to it.
- R9: In write-through mode every store makes exactly one masked word write to memory before completing. A store hit also updates the cache. A store miss does not allocate, so a later read of that block misses.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we` and `mem_addr` hold steady until the beat is accepted.
- R11: After reset every way is invalid, so the first access to any block misses, and `cpu_stall` and `mem_valid` are low while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_stall` is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 30 | Word address (byte address bits 31..2) |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte mask |
| cpu_rdata | output | 32 | Load data, valid when the request completes |
| cpu_stall | output | 1 | Request is not complete in this cycle |
| mem_valid | output | 1 | A memory beat is offered |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_we | output | 1 | 1 = word write beat, 0 = word read beat |
| mem_addr | output | 30 | Word address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_be | output | 4 | Write beat byte mask |
| mem_rdata | input | 32 | Read beat data, taken in the accepting cycle |

## Verification
A hit is due in the same cycle as its request: the stall output is already low and the read data already valid after the falling edge at which the request is driven, and the access commits at the next rising edge. A miss or a write-through store is due only once the last needed memory beat has been accepted, and the number of such beats depends on a ready pattern that stalls one cycle in three. The bench therefore samples 1 ns after each falling edge and counts stall cycles until the stall drops. It then compares the read data, the stall count (zero exactly for hits) and the read and write beats seen by the memory model with the values that its own tag/recency/dirty model predicts.

// File: rtl/dc_pkg.sv
package dc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVICT = 2'd1,
      ST_FILL  = 2'd2,
      ST_WTHRU = 2'd3
   } dc_state_e;
endpackage

// File: rtl/dc_meta.sv
module dc_meta #(
   parameter int SETS  = 64,
   parameter int SET_W = 6,
   parameter int TAG_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             hit_o,
   output logic             hit_way_o,
   output logic             vic_way_o,
   output logic             vic_dirty_o,
   output logic [TAG_W-1:0] vic_tag_o,
   input  logic             touch_i,
   input  logic             touch_way_i,
   input  logic             fill_i,
   input  logic             fill_way_i,
   input  logic             dirty_i,
   input  logic             dirty_way_i
);
   localparam int WAYS = 2;

   logic [SETS-1:0]  val_q   [WAYS];
   logic [SETS-1:0]  dirty_q [WAYS];
   logic [SETS-1:0]  lru_q;
   logic [TAG_W-1:0] tag_q   [WAYS][SETS];
   logic [WAYS-1:0]  match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = val_q[w][set_i] && (tag_q[w][set_i] == tag_i);
   end

   assign hit_o     = |match;
   assign hit_way_o = match[1];

   always_comb begin
      if (!val_q[0][set_i])      vic_way_o = 1'b0;
      else if (!val_q[1][set_i]) vic_way_o = 1'b1;
      else                       vic_way_o = lru_q[set_i];
   end

   assign vic_dirty_o = val_q[vic_way_o][set_i] && dirty_q[vic_way_o][set_i];
   assign vic_tag_o   = tag_q[vic_way_o][set_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WAYS; w++) begin
            val_q[w]   <= '0;
            dirty_q[w] <= '0;
         end
         lru_q <= '0;
      end else begin
         for (int w = 0; w < WAYS; w++) begin
            if (fill_i && (fill_way_i == 1'(w))) begin
               val_q[w][set_i]   <= 1'b1;
               dirty_q[w][set_i] <= 1'b0;
            end else if (dirty_i && (dirty_way_i == 1'(w))) begin
               dirty_q[w][set_i] <= 1'b1;
            end
         end
         if (fill_i)       lru_q[set_i] <= ~fill_way_i;
         else if (touch_i) lru_q[set_i] <= ~touch_way_i;
      end
   end

   always_ff @(posedge clk) begin
      for (int w = 0; w < WAYS; w++) begin
         if (fill_i && (fill_way_i == 1'(w))) tag_q[w][set_i] <= tag_i;
      end
   end

   // R2: a tag can live in only one way of a set
   p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/dc_data.sv
module dc_data #(
   parameter int SETS   = 64,
   parameter int WORDS  = 4,
   parameter int DW     = 32,
   parameter int SET_W  = 6,
   parameter int WOFF_W = 2
) (
   input  logic              clk,
   input  logic [SET_W-1:0]  set_i,
   input  logic              rd_way_i,
   input  logic [WOFF_W-1:0] rd_word_i,
   output logic [DW-1:0]     rdata_o,
   input  logic              we_i,
   input  logic              wr_way_i,
   input  logic [WOFF_W-1:0] wr_word_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [DW/8-1:0]   be_i
);
   localparam int BE_W = DW / 8;

   logic [DW-1:0] mem_q [2][SETS][WORDS];

   assign rdata_o = mem_q[rd_way_i][set_i][rd_word_i];

   always_ff @(posedge clk) begin
      if (we_i) begin
         for (int b = 0; b < BE_W; b++) begin
            if (be_i[b]) mem_q[wr_way_i][set_i][wr_word_i][8*b +: 8] <= wdata_i[8*b +: 8];
         end
      end
   end
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way #(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 64,
   parameter int WORDS      = 4,
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic [ADDR_W-3:0]   cpu_addr,
   input  logic [31:0]         cpu_wdata,
   input  logic [3:0]          cpu_be,
   output logic [31:0]         cpu_rdata,
   output logic                cpu_stall,
   output logic                mem_valid,
   input  logic                mem_ready,
   output logic                mem_we,
   output logic [ADDR_W-3:0]   mem_addr,
   output logic [31:0]         mem_wdata,
   output logic [3:0]          mem_be,
   input  logic [31:0]         mem_rdata
);
   import dc_pkg::*;

   localparam int DW     = 32;
   localparam int WA_W   = ADDR_W - 2;
   localparam int WOFF_W = $clog2(WORDS);
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = WA_W - SET_W - WOFF_W;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("dcache_2way: SETS must be a power of two of at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("dcache_2way: WORDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dcache_2way: address too narrow for the geometry");
   end

   logic [WOFF_W-1:0] word;
   logic [SET_W-1:0]  set;
   logic [TAG_W-1:0]  tag;
   assign word = cpu_addr[WOFF_W-1:0];
   assign set  = cpu_addr[WOFF_W +: SET_W];
   assign tag  = cpu_addr[WA_W-1 -: TAG_W];

   dc_state_e         state_q;
   logic [WOFF_W-1:0] beat_q;
   logic              vway_q;
   logic [TAG_W-1:0]  vtag_q;

   logic             hit, hit_way, vic_way, vic_dirty;
   logic [TAG_W-1:0] vic_tag;
   logic             pol_done, commit, mem_fire, beat_last;
   logic             fill_beat, store_wr;
   logic [DW-1:0]    arr_rdata;

   assign mem_fire  = mem_valid && mem_ready;
   assign beat_last = (beat_q == WOFF_W'(WORDS - 1));
   assign commit    = cpu_req && (state_q == ST_IDLE) && pol_done;
   assign cpu_stall = cpu_req && !commit;

   if (WRITE_BACK) begin : g_wb
      assign pol_done = hit;
   end else begin : g_wt
      logic wt_done_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              wt_done_q <= 1'b0;
         else if (state_q == ST_WTHRU && mem_fire) wt_done_q <= 1'b1;
         else if (commit)                         wt_done_q <= 1'b0;
      end
      assign pol_done = cpu_we ? wt_done_q : hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         vway_q  <= 1'b0;
         vtag_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (cpu_req && !pol_done) begin
               beat_q <= '0;
               vway_q <= vic_way;
               vtag_q <= vic_tag;
               if (!WRITE_BACK && cpu_we)     state_q <= ST_WTHRU;
               else if (WRITE_BACK && vic_dirty) state_q <= ST_EVICT;
               else                           state_q <= ST_FILL;
            end
            ST_EVICT: if (mem_fire) begin
               beat_q <= beat_q + 1'b1;
               if (beat_last) state_q <= ST_FILL;
            end
            ST_FILL: if (mem_fire) begin
               beat_q <= beat_q + 1'b1;
               if (beat_last) state_q <= ST_IDLE;
            end
            ST_WTHRU: if (mem_fire) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_valid = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_EVICT) || (state_q == ST_WTHRU);
   assign mem_wdata = (state_q == ST_WTHRU) ? cpu_wdata : arr_rdata;
   assign mem_be    = (state_q == ST_WTHRU) ? cpu_be : 4'hF;

   always_comb begin
      case (state_q)
         ST_EVICT: mem_addr = {vtag_q, set, beat_q};
         ST_FILL:  mem_addr = {tag, set, beat_q};
         default:  mem_addr = cpu_addr;
      endcase
   end

   assign fill_beat = (state_q == ST_FILL) && mem_fire;
   assign store_wr  = commit && cpu_we && hit;
   assign cpu_rdata = arr_rdata;

   dc_meta #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_meta (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set),
      .tag_i       (tag),
      .hit_o       (hit),
      .hit_way_o   (hit_way),
      .vic_way_o   (vic_way),
      .vic_dirty_o (vic_dirty),
      .vic_tag_o   (vic_tag),
      .touch_i     (commit && hit),
      .touch_way_i (hit_way),
      .fill_i      (fill_beat && beat_last),
      .fill_way_i  (vway_q),
      .dirty_i     (WRITE_BACK && store_wr),
      .dirty_way_i (hit_way)
   );

   dc_data #(.SETS(SETS), .WORDS(WORDS), .DW(DW), .SET_W(SET_W), .WOFF_W(WOFF_W)) u_data (
      .clk       (clk),
      .set_i     (set),
      .rd_way_i  ((state_q == ST_EVICT) ? vway_q : hit_way),
      .rd_word_i ((state_q == ST_EVICT) ? beat_q : word),
      .rdata_o   (arr_rdata),
      .we_i      (fill_beat || store_wr),
      .wr_way_i  (fill_beat ? vway_q : hit_way),
      .wr_word_i (fill_beat ? beat_q : word),
      .wdata_i   (fill_beat ? mem_rdata : cpu_wdata),
      .be_i      (fill_beat ? 4'hF : cpu_be)
   );

   // R4: once the last fill beat lands, the held request completes
   p_fill_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL && mem_fire && beat_last) |=> (cpu_req && !cpu_stall));

   // R7: a finished eviction is followed by a fill starting at word 0
   p_evict_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EVICT && mem_fire && beat_last) |=>
      (mem_valid && !mem_we && mem_addr[WOFF_W-1:0] == '0));

   // R6: in write-back mode memory writes come only from evictions
   p_wb_writes_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (WRITE_BACK && mem_valid && mem_we) |-> (state_q == ST_EVICT));

   // R9: in write-through mode a store completes right after its memory write
   p_wt_store_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!WRITE_BACK && commit && cpu_we) |-> $past(state_q == ST_WTHRU));

   // R10: an offered beat stays put until accepted
   p_beat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/tb_dcache_2way.sv
`timescale 1ns/1ps
package tb_dc_pkg;
   function automatic logic [31:0] seed_word(input logic [29:0] a);
      return {a[21:0], a[29:22] ^ 8'h5A} ^ 32'h1357_9BDF;
   endfunction
endpackage

module tb_memmodel #(parameter bit BURST_WR = 1'b1) (
   input  logic        clk,
   input  logic        valid,
   input  logic        we,
   input  logic [29:0] addr,
   input  logic [31:0] wdata,
   input  logic [3:0]  be,
   output logic        ready,
   output logic [31:0] rdata,
   output int          n_rd,
   output int          n_wr,
   output int          n_err
);
   import tb_dc_pkg::*;
   logic [31:0] store [logic [29:0]];
   int          cyc;
   logic        pend;
   logic [29:0] pend_addr;
   logic        pend_we;

   function automatic logic [31:0] peek(input logic [29:0] a);
      if (store.exists(a)) return store[a];
      return seed_word(a);
   endfunction

   initial begin
      n_rd = 0; n_wr = 0; n_err = 0; cyc = 0; pend = 0;
      ready = 0; rdata = '0; pend_addr = '0; pend_we = 0;
   end

   always @(negedge clk) begin
      logic [31:0] w;
      cyc++;
      ready = (cyc % 3) != 1;
      if (pend && (!valid || addr != pend_addr || we != pend_we)) n_err++;
      pend = 0;
      if (valid) begin
         if (ready) begin
            if (we) begin
               if (BURST_WR && addr[1:0] != 2'(n_wr)) n_err++;
               w = peek(addr);
               for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = wdata[8*b +: 8];
               store[addr] = w;
               n_wr++;
            end else begin
               if (addr[1:0] != 2'(n_rd)) n_err++;
               rdata = peek(addr);
               n_rd++;
            end
         end else begin
            pend = 1; pend_addr = addr; pend_we = we;
         end
      end
   end
endmodule

module tb_dcache_2way;
   import tb_dc_pkg::*;

   logic clk = 0;
   logic rst_n = 0;
   always #2 clk = ~clk;

   logic        req = 0, mode = 0;
   logic        cpu_we = 0;
   logic [29:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;

   logic [31:0] rd_wb, rd_wt, mrd_wb, mrd_wt, mwd_wb, mwd_wt;
   logic        st_wb, st_wt, mv_wb, mv_wt, mr_wb, mr_wt, mw_wb, mw_wt;
   logic [29:0] ma_wb, ma_wt;
   logic [3:0]  mb_wb, mb_wt;
   int          nr_wb, nw_wb, ne_wb, nr_wt, nw_wt, ne_wt;

   dcache_2way #(.WRITE_BACK(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(req && !mode), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_rdata(rd_wb), .cpu_stall(st_wb), .mem_valid(mv_wb), .mem_ready(mr_wb),
      .mem_we(mw_wb), .mem_addr(ma_wb), .mem_wdata(mwd_wb), .mem_be(mb_wb),
      .mem_rdata(mrd_wb));

   dcache_2way #(.WRITE_BACK(1'b0)) dut_wt (
      .clk(clk), .rst_n(rst_n), .cpu_req(req && mode), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_rdata(rd_wt), .cpu_stall(st_wt), .mem_valid(mv_wt), .mem_ready(mr_wt),
      .mem_we(mw_wt), .mem_addr(ma_wt), .mem_wdata(mwd_wt), .mem_be(mb_wt),
      .mem_rdata(mrd_wt));

   tb_memmodel #(.BURST_WR(1'b1)) mem_wb (
      .clk(clk), .valid(mv_wb), .we(mw_wb), .addr(ma_wb), .wdata(mwd_wb), .be(mb_wb),
      .ready(mr_wb), .rdata(mrd_wb), .n_rd(nr_wb), .n_wr(nw_wb), .n_err(ne_wb));

   tb_memmodel #(.BURST_WR(1'b0)) mem_wt (
      .clk(clk), .valid(mv_wt), .we(mw_wt), .addr(ma_wt), .wdata(mwd_wt), .be(mb_wt),
      .ready(mr_wt), .rdata(mrd_wt), .n_rd(nr_wt), .n_wr(nw_wt), .n_err(ne_wt));

   int n_chk = 0, n_fail = 0;

   // bench-side model of the cache state, indexed [mode][set][way]
   bit          m_val [2][64][2];
   bit          m_dty [2][64][2];
   logic [21:0] m_tag [2][64][2];
   bit          m_lru [2][64];
   logic [31:0] shadow [logic [30:0]];

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic do_access(input bit we, input logic [21:0] tg, input logic [5:0] st,
                            input logic [1:0] wd, input logic [31:0] dat,
                            input logic [3:0] bm, input string rq);
      logic [29:0] a;
      logic [30:0] key;
      logic [31:0] expd, got, merged;
      int m, hw, vw, exp_rd, exp_wr, rd0, wr0, stalls;
      bit hit, exp_stall;
      a = {tg, st, wd};
      m = int'(mode);
      key = {mode, a};
      expd = shadow.exists(key) ? shadow[key] : seed_word(a);
      hw = -1; exp_rd = 0; exp_wr = 0; stalls = 0;
      for (int w = 0; w < 2; w++) if (m_val[m][st][w] && m_tag[m][st][w] == tg) hw = w;
      hit = (hw >= 0);
      exp_stall = !hit || (m == 1 && we);
      if (!hit && !(m == 1 && we)) begin
         vw = !m_val[m][st][0] ? 0 : (!m_val[m][st][1] ? 1 : int'(m_lru[m][st]));
         exp_rd = 4;
         exp_wr = (m_val[m][st][vw] && m_dty[m][st][vw]) ? 4 : 0;
         m_val[m][st][vw] = 1; m_dty[m][st][vw] = 0; m_tag[m][st][vw] = tg;
         hw = vw;
      end
      if (m == 1 && we) exp_wr = 1;
      if (hw >= 0) begin
         m_lru[m][st] = (hw == 0);
         if (we && m == 0) m_dty[m][st][hw] = 1;
      end
      rd0 = m ? nr_wt : nr_wb;
      wr0 = m ? nw_wt : nw_wb;
      @(negedge clk);
      req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = dat; cpu_be = bm;
      #1;
      while ((mode ? st_wt : st_wb) && stalls < 400) begin
         @(negedge clk); #1; stalls++;
      end
      got = mode ? rd_wt : rd_wb;
      @(negedge clk);
      req = 0; cpu_we = 0;
      #1;
      check((stalls != 0) == exp_stall, rq, "stall cycles", 32'(stalls), 32'(exp_stall));
      check(((m ? nr_wt : nr_wb) - rd0) == exp_rd, rq, "read beats",
            32'((m ? nr_wt : nr_wb) - rd0), 32'(exp_rd));
      check(((m ? nw_wt : nw_wb) - wr0) == exp_wr, rq, "write beats",
            32'((m ? nw_wt : nw_wb) - wr0), 32'(exp_wr));
      if (!we) begin
         check(got == expd, rq, "read data", got, expd);
      end else begin
         merged = expd;
         for (int b = 0; b < 4; b++) if (bm[b]) merged[8*b +: 8] = dat[8*b +: 8];
         shadow[key] = merged;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] lcg;
      lcg = 32'h2468_ACE1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R11: idle after reset
      check(!st_wb && !st_wt, "R11", "stall while idle", {st_wb, st_wt}, 0);
      check(!mv_wb && !mv_wt, "R11", "memory idle", {mv_wb, mv_wt}, 0);

      // write-back configuration
      mode = 0;
      do_access(0, 22'd1, 6'd5, 2'd2, 0, 0, "R11 R4 cold read");
      do_access(0, 22'd1, 6'd5, 2'd0, 0, 0, "R2 hit read");
      do_access(0, 22'd2, 6'd5, 2'd1, 0, 0, "R3 fill free way");
      do_access(0, 22'd1, 6'd5, 2'd3, 0, 0, "R3 recency touch");
      do_access(1, 22'd1, 6'd5, 2'd1, 32'hDEAD_BEEF, 4'b0101, "R6 R5 store hit");
      do_access(0, 22'd3, 6'd5, 2'd0, 0, 0, "R3 evict least recent clean");
      do_access(0, 22'd4, 6'd5, 2'd0, 0, 0, "R7 dirty eviction");
      do_access(0, 22'd1, 6'd5, 2'd1, 0, 0, "R5 R7 merged bytes kept");
      do_access(1, 22'd6, 6'd9, 2'd2, 32'h0BAD_F00D, 4'b1110, "R8 store miss allocate");
      do_access(0, 22'd6, 6'd9, 2'd2, 0, 0, "R8 read after allocate");
      for (int s = 0; s < 64; s++)
         do_access(0, 22'h2A5A5, 6'(s), 2'(s), 0, 0, "R1 set sweep");
      for (int s = 0; s < 64; s++)
         do_access(0, 22'h2A5A5, 6'(s), 2'(s + 1), 0, 0, "R1 R2 sweep rehit");
      for (int i = 0; i < 1200; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         do_access(lcg[20:18] < 3'd2, 22'(lcg[17:16]), 6'(lcg[15:14]), lcg[13:12],
                   {lcg[11:0], lcg[31:12]}, (lcg[23:21] == 0) ? 4'hF : 4'(lcg[24:21]),
                   "R2 R3 R4 R6 R7 R8 random");
      end

      // write-through configuration
      mode = 1;
      do_access(1, 22'd7, 6'd3, 2'd1, 32'h1111_2222, 4'b0011, "R9 store miss no allocate");
      do_access(0, 22'd7, 6'd3, 2'd1, 0, 0, "R9 R5 read after store miss");
      do_access(1, 22'd7, 6'd3, 2'd0, 32'hCAFE_0001, 4'b1000, "R9 store hit");
      do_access(0, 22'd7, 6'd3, 2'd0, 0, 0, "R9 hit sees store");
      do_access(0, 22'd8, 6'd3, 2'd0, 0, 0, "R9 R3 fill second way");
      do_access(0, 22'd9, 6'd3, 2'd0, 0, 0, "R9 R3 clean replace");
      for (int i = 0; i < 1200; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         do_access(lcg[20:18] < 3'd2, 22'(lcg[17:16]), 6'(lcg[15:14]), lcg[13:12],
                   {lcg[11:0], lcg[31:12]}, (lcg[23:21] == 0) ? 4'hF : 4'(lcg[24:21]),
                   "R9 R2 R4 random");
      end

      check(ne_wb == 0, "R10 R4", "write-back beat order/hold errors", 32'(ne_wb), 0);
      check(ne_wt == 0, "R10 R4", "write-through beat order/hold errors", 32'(ne_wt), 0);
      summary();
      $finish;
   end
endmodule